// File: doc/BRIEF.md
# Receive Frame Statistics Counter Bank

This block keeps the receive-side RMON statistics of an Ethernet MAC. The frame parser and CRC checker upstream send it one report at the end of every received frame. The report carries the frame length in bytes, a bad-FCS flag, an alignment-error flag and the destination address class. The bank sorts each report into traffic, error and length-histogram categories and increments every 64-bit counter that the report touches, all in the same clock cycle. Length categories are judged against a programmable maximum frame length.

Software reads the counters through a word-wide read port. Each 64-bit counter takes two consecutive word addresses. A read of the upper half also captures the lower half of the same counter into a shadow register. The following lower-half read returns that captured value, so a two-word read is coherent even while frames keep arriving.

Top module: `rx_stat_bank`

## Requirements
- R1: After reset every counter reads zero, `rd_data` is zero and the maximum frame length is 1536 bytes.
- R2: Counter k has its upper 32 bits at word address 2k and its lower 32 bits at 2k+1. Data appears on `rd_data` in the cycle after `rd_en`. Addresses at or above 40 read zero. The counter indices are: 0 good frames, 1 good octets, 2 unicast, 3 multicast, 4 broadcast, 5 FCS errors, 6 alignment errors, 7 too-long frames, 8 undersize, 9 fragments, 10 oversize, 11 jabber, 12 receive errors, 13 to 19 length bins.
- R3: A read of an upper-half address captures the lower half of that counter, and a read of any lower-half address returns the most recent captured value, even if the counter has changed since.
- R4: A frame is good when its length lies between 64 and the maximum inclusive and neither error flag is set. A good frame adds one to the good-frame counter, adds its length to the octet counter and adds one to the class counter selected by `rpt_cls` (0 unicast, 1 multicast, 2 broadcast, 3 none).
- R5: Every frame whose length lies between 64 and the maximum, errored or not, increments exactly one length bin: 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, or 1519 to the maximum.
- R6: A frame shorter than 64 bytes counts as undersize when its FCS is good and as a fragment when its FCS is bad.
- R7: A frame longer than the maximum increments the too-long counter, plus the oversize counter when its FCS is good or the jabber counter when its FCS is bad.
- R8: `rpt_fcs_err` and `rpt_align_err` each increment their own error counter independently of length.
- R9: The receive-error counter increments once for any frame that has an FCS error, an alignment error, or a length outside 64 up to the maximum.
- R10: Writing `cfg_max_len` with `cfg_we` sets the maximum frame length used for reports from the next cycle onward.
- R11: All counters touched by a report change together at the clock edge that accepts it. A read issued in that same cycle returns the value before the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | Frame report present this cycle |
| rpt_len | input | 16 | Frame length in bytes |
| rpt_fcs_err | input | 1 | Frame had a bad FCS |
| rpt_align_err | input | 1 | Frame had an alignment error |
| rpt_cls | input | 2 | Address class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| cfg_we | input | 1 | Write the maximum frame length |
| cfg_max_len | input | 16 | New maximum frame length |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Word address of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
The bench sends frames at every bin edge (63, 64, 65, 127, 128, 1518, 1519, the maximum and one past it). A design with an off-by-one comparison would put such a frame into the neighbouring bin, or would count it as good instead of oversize. Errored frames inside the length range must still reach the histogram and the error counter but must stay out of the good, octet and class counters; a design that gated the bins on good FCS would fall behind the model. A lower-half read after further traffic must return the stale captured value, which catches a design that reads the live counter. The bench also moves the maximum length up and down between frames to show that the new limit takes effect at once.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CNT_W  = 64;
  localparam int WORD_W = 32;
  localparam int NBIN   = 7;
  localparam int NCNT   = 13 + NBIN;
  localparam int NWORD  = 2 * NCNT;
  localparam int RA_W   = $clog2(NWORD);

  localparam int C_GOOD  = 0;
  localparam int C_OCT   = 1;
  localparam int C_UNI   = 2;
  localparam int C_MUL   = 3;
  localparam int C_BC    = 4;
  localparam int C_FCS   = 5;
  localparam int C_ALN   = 6;
  localparam int C_LONG  = 7;
  localparam int C_UNDER = 8;
  localparam int C_FRAG  = 9;
  localparam int C_OVER  = 10;
  localparam int C_JAB   = 11;
  localparam int C_ERR   = 12;
  localparam int C_BIN0  = 13;

  localparam int MIN_LEN     = 64;
  localparam int DEF_MAX_LEN = 1536;

  // lower edge of each length bin; the upper edge is the next lower edge minus one
  localparam int BIN_LO [NBIN] = '{64, 65, 128, 256, 512, 1024, 1519};

  typedef enum logic [1:0] {
    CLS_UNI  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_BC   = 2'd2,
    CLS_NONE = 2'd3
  } cls_e;
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             valid,
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_err,
  input  logic             align_err,
  input  logic [1:0]       cls,
  input  logic [LEN_W-1:0] max_len,
  output logic [NCNT-1:0]  inc
);
  logic            is_short, is_long, in_rng, is_good;
  logic [NBIN-1:0] bin_hit;

  assign is_short = len < LEN_W'(MIN_LEN);
  assign is_long  = len > max_len;
  assign in_rng   = !is_short && !is_long;
  assign is_good  = in_rng && !fcs_err && !align_err;

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    if (b == NBIN - 1) begin : g_top
      assign bin_hit[b] = len >= LEN_W'(BIN_LO[b]);
    end else begin : g_mid
      assign bin_hit[b] = (len >= LEN_W'(BIN_LO[b])) && (len < LEN_W'(BIN_LO[b+1]));
    end
  end

  always_comb begin
    inc          = '0;
    inc[C_GOOD]  = valid && is_good;
    inc[C_OCT]   = valid && is_good;
    inc[C_UNI]   = valid && is_good && (cls_e'(cls) == CLS_UNI);
    inc[C_MUL]   = valid && is_good && (cls_e'(cls) == CLS_MUL);
    inc[C_BC]    = valid && is_good && (cls_e'(cls) == CLS_BC);
    inc[C_FCS]   = valid && fcs_err;
    inc[C_ALN]   = valid && align_err;
    inc[C_LONG]  = valid && is_long;
    inc[C_UNDER] = valid && is_short && !fcs_err;
    inc[C_FRAG]  = valid && is_short && fcs_err;
    inc[C_OVER]  = valid && is_long && !fcs_err;
    inc[C_JAB]   = valid && is_long && fcs_err;
    inc[C_ERR]   = valid && (fcs_err || align_err || !in_rng);
    for (int b = 0; b < NBIN; b++) begin
      inc[C_BIN0+b] = valid && in_rng && bin_hit[b];
    end
  end
endmodule

// File: rtl/rxs_cnt.sv
module rxs_cnt #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] add,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q + add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/rxs_readout.sv
module rxs_readout
  import rxs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [RA_W-1:0]      rd_addr,
  input  logic [NCNT*CNT_W-1:0] cnt_flat,
  output logic [WORD_W-1:0]    rd_data,
  output logic [WORD_W-1:0]    shadow
);
  logic [CNT_W-1:0]  sel;
  logic [WORD_W-1:0] data_d, shadow_d;
  logic              in_rng;
  logic              upd_data, upd_shadow;

  assign in_rng = rd_addr < RA_W'(NWORD);

  always_comb begin
    sel = '0;
    for (int k = 0; k < NCNT; k++) begin
      if (rd_addr[RA_W-1:1] == (RA_W-1)'(k)) begin
        sel = cnt_flat[k*CNT_W +: CNT_W];
      end
    end
  end

  always_comb begin
    data_d     = '0;
    shadow_d   = shadow;
    upd_data   = rd_en;
    upd_shadow = 1'b0;
    if (in_rng) begin
      if (!rd_addr[0]) begin
        data_d     = sel[CNT_W-1:WORD_W];
        shadow_d   = sel[WORD_W-1:0];
        upd_shadow = rd_en;
      end else begin
        data_d = shadow;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (upd_data) begin
      rd_data <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (upd_shadow) begin
      shadow <= shadow_d;
    end
  end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  input  logic [LEN_W-1:0]  rpt_len,
  input  logic              rpt_fcs_err,
  input  logic              rpt_align_err,
  input  logic [1:0]        rpt_cls,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              rd_en,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [LEN_W-1:0]       max_q, max_d;
  logic [NCNT-1:0]        inc_w;
  logic [NCNT*CNT_W-1:0]  cnt_flat;
  logic [WORD_W-1:0]      shadow_w;

  always_comb begin
    max_d = cfg_max_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= LEN_W'(DEF_MAX_LEN);
    end else if (cfg_we) begin
      max_q <= max_d;
    end
  end

  rxs_classify #(.LEN_W(LEN_W)) u_cls (
    .valid     (rpt_valid),
    .len       (rpt_len),
    .fcs_err   (rpt_fcs_err),
    .align_err (rpt_align_err),
    .cls       (rpt_cls),
    .max_len   (max_q),
    .inc       (inc_w)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [CNT_W-1:0] add_w;
    if (i == C_OCT) begin : g_oct
      assign add_w = CNT_W'(rpt_len);
    end else begin : g_one
      assign add_w = CNT_W'(1);
    end
    rxs_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (inc_w[i]),
      .add   (add_w),
      .q     (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  rxs_readout u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cnt_flat (cnt_flat),
    .rd_data  (rd_data),
    .shadow   (shadow_w)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [LEN_W-1:0]      cfg_max_len,
  input logic                  rd_en,
  input logic [RA_W-1:0]       rd_addr,
  input logic [WORD_W-1:0]     rd_data,
  input logic [LEN_W-1:0]      max_len,
  input logic [NCNT-1:0]       inc,
  input logic [NCNT*CNT_W-1:0] cnt_flat,
  input logic [WORD_W-1:0]     shadow
);
  logic [WORD_W-1:0] low_sel;
  logic [CNT_W-1:0]  good_cnt;

  assign good_cnt = cnt_flat[C_GOOD*CNT_W +: CNT_W];

  always_comb begin
    low_sel = '0;
    for (int k = 0; k < NCNT; k++) begin
      if (rd_addr[RA_W-1:1] == (RA_W-1)'(k)) begin
        low_sel = cnt_flat[k*CNT_W +: WORD_W];
      end
    end
  end

  p_oor_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= RA_W'(NWORD)) |=> (rd_data == '0));

  p_shadow_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[0] && rd_addr < RA_W'(NWORD)) |=> (shadow == $past(low_sel)));

  p_one_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc[C_BC:C_UNI]));

  p_one_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc[NCNT-1:C_BIN0]));

  p_size_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc[C_GOOD], inc[C_UNDER], inc[C_FRAG], inc[C_OVER], inc[C_JAB]}));

  p_long_tally_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[C_OVER] || inc[C_JAB]) |-> inc[C_LONG]);

  p_err_tally_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[C_FCS] || inc[C_ALN] || inc[C_UNDER] || inc[C_FRAG] || inc[C_LONG]) |-> inc[C_ERR]);

  p_cfg_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (max_len == $past(cfg_max_len)));

  p_good_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc[C_GOOD] |=> (good_cnt == $past(good_cnt) + 64'd1));
endmodule

bind rx_stat_bank rxs_checker #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_max_len (cfg_max_len),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .max_len     (max_q),
  .inc         (inc_w),
  .cnt_flat    (cnt_flat),
  .shadow      (shadow_w)
);

// File: tb/test_rx_stat_bank.sv
module test_rx_stat_bank;
  localparam int NC = 20;
  localparam int NW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_valid = 1'b0;
  logic [15:0] rpt_len = '0;
  logic        rpt_fcs_err = 1'b0;
  logic        rpt_align_err = 1'b0;
  logic [1:0]  rpt_cls = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_max_len = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;

  rx_stat_bank i_rx_stat_bank (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_len(rpt_len),
    .rpt_fcs_err(rpt_fcs_err), .rpt_align_err(rpt_align_err), .rpt_cls(rpt_cls),
    .cfg_we(cfg_we), .cfg_max_len(cfg_max_len), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint unsigned mdl [NC];
  logic [31:0] msh = '0;
  int mlen = 1536;
  int ra = 0;
  string ptag = "";

  function automatic string tag_of(int k);
    if (k <= 4) return "R4";
    if (k <= 6) return "R8";
    if (k == 7 || k == 10 || k == 11) return "R7";
    if (k <= 9) return "R6";
    if (k == 12) return "R9";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_frame(int len, bit f, bit a, int c);
    bit rng;
    rng = (len >= 64) && (len <= mlen);
    if (f) mdl[5]++;
    if (a) mdl[6]++;
    if (f || a || !rng) mdl[12]++;
    if (len < 64) begin
      if (f) mdl[9]++; else mdl[8]++;
    end else if (len > mlen) begin
      mdl[7]++;
      if (f) mdl[11]++; else mdl[10]++;
    end else begin
      if (len == 64) mdl[13]++;
      else if (len < 128) mdl[14]++;
      else if (len < 256) mdl[15]++;
      else if (len < 512) mdl[16]++;
      else if (len < 1024) mdl[17]++;
      else if (len < 1519) mdl[18]++;
      else mdl[19]++;
      if (!f && !a) begin
        mdl[0]++;
        mdl[1] += longint'(len);
        if (c < 3) mdl[2+c]++;
      end
    end
  endtask

  // one clock: optional report, optional read, optional config write
  task automatic cyc(bit v, int len, bit f, bit a, int c, bit re, int addr,
                     bit we = 1'b0, int newmax = 0);
    logic [31:0] exp;
    logic [31:0] nsh;
    string tg;
    @(negedge clk);
    rpt_valid = v; rpt_len = 16'(len); rpt_fcs_err = f; rpt_align_err = a;
    rpt_cls = 2'(c); rd_en = re; rd_addr = 6'(addr);
    cfg_we = we; cfg_max_len = 16'(newmax);
    nsh = msh;
    exp = '0;
    if (addr >= NW) begin
      tg = "R2";
    end else if (addr % 2 == 0) begin
      exp = mdl[addr/2][63:32];
      nsh = mdl[addr/2][31:0];
      tg = {tag_of(addr/2), " R2"};
    end else begin
      exp = msh;
      tg = {tag_of(addr/2), " R3"};
    end
    @(posedge clk);
    #1;
    if (re) begin
      chk({tg, " ", ptag}, rd_data, exp);
      msh = nsh;
    end
    if (v) model_frame(len, f, a, c);
    if (we) mlen = newmax;
  endtask

  task automatic roll(bit v, int len, bit f, bit a, int c);
    cyc(v, len, f, a, c, 1'b1, ra);
    ra = (ra + 1) % (NW + 4);
  endtask

  task automatic sweep();
    for (int w = 0; w < NW + 4; w++) cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, w);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) mdl[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rd_data", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ptag = "R1";
    sweep();

    // bin edges and length categories at the default maximum
    ptag = "R5";
    roll(1'b1, 63, 1'b0, 1'b0, 0);
    roll(1'b1, 40, 1'b1, 1'b0, 1);
    roll(1'b1, 64, 1'b0, 1'b0, 0);
    roll(1'b1, 65, 1'b0, 1'b0, 1);
    roll(1'b1, 127, 1'b0, 1'b0, 2);
    roll(1'b1, 128, 1'b0, 1'b0, 3);
    roll(1'b1, 255, 1'b1, 1'b0, 0);
    roll(1'b1, 256, 1'b0, 1'b1, 1);
    roll(1'b1, 511, 1'b0, 1'b0, 2);
    roll(1'b1, 512, 1'b0, 1'b0, 0);
    roll(1'b1, 1023, 1'b0, 1'b0, 1);
    roll(1'b1, 1024, 1'b0, 1'b0, 2);
    roll(1'b1, 1518, 1'b0, 1'b0, 0);
    roll(1'b1, 1519, 1'b0, 1'b0, 1);
    roll(1'b1, 1536, 1'b0, 1'b0, 2);
    roll(1'b1, 1537, 1'b0, 1'b0, 0);
    roll(1'b1, 2000, 1'b1, 1'b0, 0);
    roll(1'b1, 1600, 1'b0, 1'b1, 2);
    sweep();

    // mixed traffic; every read lands in the same cycle as a report (R11)
    ptag = "R11";
    for (int i = 0; i < 400; i++) begin
      roll(1'b1, 20 + (i * 73 + i * i * 7) % 1650, (i % 7) == 3, (i % 11) == 5, i % 4);
    end
    sweep();

    // coherent split read: capture octet lower half, then keep counting
    ptag = "R3";
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 2);
    for (int i = 0; i < 5; i++) cyc(1'b1, 300 + i, 1'b0, 1'b0, 0, 1'b0, 0);
    cyc(1'b1, 90, 1'b0, 1'b0, 1, 1'b1, 3);
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 1);
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 0);
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 1);

    // programmable maximum: raise, then lower, frame right after the write
    ptag = "R10";
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 1600);
    roll(1'b1, 1600, 1'b0, 1'b0, 0);
    roll(1'b1, 1601, 1'b0, 1'b0, 0);
    roll(1'b1, 1601, 1'b1, 1'b0, 1);
    cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 1000);
    roll(1'b1, 1000, 1'b0, 1'b0, 2);
    roll(1'b1, 1001, 1'b0, 1'b0, 2);
    roll(1'b1, 1200, 1'b1, 1'b0, 0);
    for (int i = 0; i < 60; i++) roll(1'b1, 900 + i * 3, (i % 5) == 0, 1'b0, i % 4);
    sweep();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule